// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio of the form N = P·B + A. It is meant to sit in the feedback path of a phase-locked loop, where it turns the oscillator clock into a slow comparison pulse. A two-modulus prescaler divides the input by either P or P+1. A swallow counter (A) and a main counter (B) count the prescaler output periods. While the swallow counter is nonzero, the prescaler runs in its longer P+1 mode. After that it falls back to P until the main counter runs out. The division cycle then ends, one output pulse is emitted, and both counters reload.

The prescaler is a synchronous divide-by-4/5 core followed by a binary extension stage of 1 to 4 bits. Together they give the pairs 8/9, 16/17, 32/33 and 64/65. A settings word (select, A, B) is applied in parallel. The block checks it on every clock. A valid word takes effect only at a cycle boundary. An invalid word is flagged, and the block keeps running on the last good settings.

Top module: `pswallow_div`

## Requirements
- R1: One `div_out` pulse, exactly one input clock wide, appears every P·B+A rising edges. With a valid setting applied during reset, the first pulse is seen after the N-th edge following reset release.
- R2: `psel` chooses the lower modulus P: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64. The upper modulus is always P+1.
- R3: With A = 0, every prescaler period uses P, so the ratio is P·B.
- R4: With A = B, every prescaler period uses P+1, so the ratio is (P+1)·B.
- R5: A setting with A > B or B < 3 raises `cfg_err` one edge after it is presented, and the error clears one edge after a valid setting returns. While the setting is invalid, the running ratio stays at the last valid setting.
- R6: A valid new setting presented in the middle of a division cycle does not change that cycle's length. It governs every cycle that starts after the next boundary.
- R7: A synchronous active-high `rst` drives `div_out` and `cfg_err` low and restarts the prescaler and both counters.
- R8: The extremes B = 3 and B = 8191 (the 13-bit maximum) and A = 63 (the 6-bit maximum) are accepted and divide correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | High-rate input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 2 | Prescaler pair select |
| a_cfg | input | 6 | Swallow count A |
| b_cfg | input | 13 | Main count B |
| div_out | output | 1 | One-clock pulse at the end of each division cycle |
| cfg_err | output | 1 | High when the presented setting is invalid |

## Verification
Two events can fall in the same edge: the end of a division cycle and the arrival of a new setting, whether valid or invalid. That edge must both finish the old cycle and decide which setting the next cycle uses. The bench provokes this by changing the setting on the cycle right after a pulse, by leaving an invalid setting in place across a boundary, and by changing the setting in the middle of a cycle. It then measures the remaining length of the current cycle and the full length of the following one, and compares them with ratios computed from the old and the new settings.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int SEL_W  = 2;
  localparam int A_W    = 6;
  localparam int B_W    = 13;
  localparam int B_MIN  = 3;
  localparam int CORE_W = 3;
  localparam int EXT_W  = 1 << SEL_W;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [A_W-1:0]   a;
    logic [B_W-1:0]   b;
  } div_cfg_t;

  localparam div_cfg_t CFG_DEFAULT = '{sel: '0, a: '0, b: B_W'(B_MIN)};

  // a setting is usable when B reaches its minimum and A never exceeds B
  function automatic logic cfg_ok(input div_cfg_t c);
    return (c.b >= B_W'(B_MIN)) && ({{(B_W-A_W){1'b0}}, c.a} <= c.b);
  endfunction

  // lower prescaler modulus: 4/5 core times 2**(sel+1)
  function automatic logic [7:0] low_modulus(input logic [SEL_W-1:0] sel);
    return 8'(4) << (int'(sel) + 1);
  endfunction

  // overall ratio P*B + A
  function automatic logic [20:0] total_ratio(input div_cfg_t c);
    return 21'(low_modulus(c.sel)) * 21'(c.b) + 21'(c.a);
  endfunction
endpackage

// File: rtl/pswallow_cfg.sv
module pswallow_cfg
  import pswallow_pkg::*;
(
  input  logic     clk_in,
  input  logic     rst,
  input  div_cfg_t port_cfg,
  input  logic     cyc_end,
  output logic     port_ok,
  output div_cfg_t nxt_cfg,
  output div_cfg_t act_cfg
);
  div_cfg_t act_q;

  always_comb begin
    port_ok = cfg_ok(port_cfg);
    if (port_ok)  nxt_cfg = port_cfg;
    else if (rst) nxt_cfg = CFG_DEFAULT;
    else          nxt_cfg = act_q;
  end

  always_ff @(posedge clk_in) begin
    if (rst || cyc_end) act_q <= nxt_cfg;
  end

  assign act_cfg = act_q;
endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler #(
  parameter int SEL_W  = 2,
  parameter int CORE_W = 3,
  parameter int EXT_W  = 4
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             mc,
  output logic             pre_tc
);
  localparam logic [CORE_W-1:0] CORE_LAST4 = CORE_W'(3);
  localparam logic [CORE_W-1:0] CORE_LAST5 = CORE_W'(4);

  logic [CORE_W-1:0] core_q, core_last;
  logic [EXT_W-1:0]  ext_q, ext_mask;
  logic              ext_term, core_wrap;

  always_comb begin
    ext_mask  = EXT_W'((1 << (int'(sel) + 1)) - 1);
    ext_term  = (ext_q & ext_mask) == ext_mask;
    // the 4/5 core takes its extra state once per extension round
    core_last = (mc && ext_term) ? CORE_LAST5 : CORE_LAST4;
    core_wrap = core_q == core_last;
    pre_tc    = core_wrap && ext_term;
  end

  always_ff @(posedge clk_in) begin
    if (rst) begin
      core_q <= '0;
      ext_q  <= '0;
    end else if (core_wrap) begin
      core_q <= '0;
      ext_q  <= (ext_q + EXT_W'(1)) & ext_mask;
    end else begin
      core_q <= core_q + CORE_W'(1);
    end
  end
endmodule

// File: rtl/pswallow_counters.sv
module pswallow_counters #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk_in,
  input  logic           rst,
  input  logic           pre_tc,
  input  logic [A_W-1:0] a_ld,
  input  logic [B_W-1:0] b_ld,
  output logic           mc,
  output logic           cyc_end,
  output logic [A_W-1:0] a_cnt,
  output logic [B_W-1:0] b_cnt
);
  assign mc      = a_cnt != '0;
  assign cyc_end = pre_tc && (b_cnt == B_W'(1));

  always_ff @(posedge clk_in) begin
    if (rst || cyc_end) begin
      a_cnt <= a_ld;
      b_cnt <= b_ld;
    end else if (pre_tc) begin
      b_cnt <= b_cnt - B_W'(1);
      if (mc) a_cnt <= a_cnt - A_W'(1);
    end
  end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
(
  input  logic             clk_in,
  input  logic             rst,
  input  logic [SEL_W-1:0] psel,
  input  logic [A_W-1:0]   a_cfg,
  input  logic [B_W-1:0]   b_cfg,
  output logic             div_out,
  output logic             cfg_err
);
  div_cfg_t port_cfg, nxt_cfg, act_cfg;
  logic port_ok, pre_tc, mc, cyc_end;
  logic [A_W-1:0]   a_cnt;
  logic [B_W-1:0]   b_cnt;
  logic [SEL_W-1:0] act_sel;
  logic [A_W-1:0]   act_a;
  logic [B_W-1:0]   act_b;
  logic div_q, err_q;

  assign port_cfg = '{sel: psel, a: a_cfg, b: b_cfg};
  assign act_sel  = act_cfg.sel;
  assign act_a    = act_cfg.a;
  assign act_b    = act_cfg.b;

  pswallow_cfg u_cfg (
    .clk_in(clk_in), .rst(rst), .port_cfg(port_cfg), .cyc_end(cyc_end),
    .port_ok(port_ok), .nxt_cfg(nxt_cfg), .act_cfg(act_cfg)
  );

  pswallow_prescaler #(.SEL_W(SEL_W), .CORE_W(CORE_W), .EXT_W(EXT_W)) u_pre (
    .clk_in(clk_in), .rst(rst), .sel(act_sel), .mc(mc), .pre_tc(pre_tc)
  );

  pswallow_counters #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk_in(clk_in), .rst(rst), .pre_tc(pre_tc),
    .a_ld(nxt_cfg.a), .b_ld(nxt_cfg.b),
    .mc(mc), .cyc_end(cyc_end), .a_cnt(a_cnt), .b_cnt(b_cnt)
  );

  always_ff @(posedge clk_in) begin
    if (rst) begin
      div_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      div_q <= cyc_end;
      err_q <= !port_ok;
    end
  end

  assign div_out = div_q;
  assign cfg_err = err_q;
endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk
  import pswallow_pkg::*;
(
  input logic             clk_in,
  input logic             rst,
  input logic [SEL_W-1:0] psel,
  input logic [A_W-1:0]   a_cfg,
  input logic [B_W-1:0]   b_cfg,
  input logic             div_out,
  input logic             cfg_err,
  input logic             pre_tc,
  input logic             cyc_end,
  input logic             mc,
  input logic [A_W-1:0]   a_cnt,
  input logic [B_W-1:0]   b_cnt,
  input logic [SEL_W-1:0] act_sel,
  input logic [A_W-1:0]   act_a,
  input logic [B_W-1:0]   act_b
);
  logic [6:0] per_cnt;
  logic       bad_port;

  assign bad_port = (b_cfg < B_W'(3)) || (B_W'(a_cfg) > b_cfg);

  always_ff @(posedge clk_in) begin
    if (rst || pre_tc) per_cnt <= '0;
    else               per_cnt <= per_cnt + 7'd1;
  end

  a_r1_single_pulse: assert property (@(posedge clk_in) disable iff (rst)
    div_out |=> !div_out);
  a_r1_pulse_at_end: assert property (@(posedge clk_in) disable iff (rst)
    cyc_end |=> div_out);
  a_r1_b_steps: assert property (@(posedge clk_in) disable iff (rst)
    (pre_tc && !cyc_end) |=> (b_cnt == $past(b_cnt) - B_W'(1)));
  a_r2_modulus: assert property (@(posedge clk_in) disable iff (rst)
    pre_tc |-> (8'(per_cnt) + 8'd1 == (8'd8 << act_sel) + 8'(mc)));
  a_r4_a_le_b: assert property (@(posedge clk_in) disable iff (rst)
    B_W'(a_cnt) <= b_cnt);
  a_r5_err_set: assert property (@(posedge clk_in) disable iff (rst)
    bad_port |=> cfg_err);
  a_r5_err_clr: assert property (@(posedge clk_in) disable iff (rst)
    !bad_port |=> !cfg_err);
  a_r5_active_valid: assert property (@(posedge clk_in) disable iff (rst)
    (act_b >= B_W'(3)) && (B_W'(act_a) <= act_b));
  a_r6_hold_midcycle: assert property (@(posedge clk_in) disable iff (rst)
    !cyc_end |=> $stable({act_sel, act_a, act_b}));
endmodule

bind pswallow_div pswallow_div_chk u_chk (
  .clk_in(clk_in), .rst(rst), .psel(psel), .a_cfg(a_cfg), .b_cfg(b_cfg),
  .div_out(div_out), .cfg_err(cfg_err), .pre_tc(pre_tc), .cyc_end(cyc_end),
  .mc(mc), .a_cnt(a_cnt), .b_cnt(b_cnt),
  .act_sel(act_sel), .act_a(act_a), .act_b(act_b)
);

// File: tb/sim_pswallow_div.sv
module sim_pswallow_div;
  logic clk_in = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  psel = 2'd0;
  logic [5:0]  a_cfg = 6'd5;
  logic [12:0] b_cfg = 13'd10;
  logic div_out, cfg_err;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk_in = ~clk_in;

  pswallow_div u0 (
    .clk_in(clk_in), .rst(rst), .psel(psel), .a_cfg(a_cfg), .b_cfg(b_cfg),
    .div_out(div_out), .cfg_err(cfg_err)
  );

  // {psel, A, B}
  localparam logic [20:0] VEC [8] = '{
    {2'd0, 6'd5,  13'd10}, {2'd1, 6'd3,  13'd4},  {2'd2, 6'd0, 13'd3},
    {2'd3, 6'd2,  13'd3},  {2'd0, 6'd63, 13'd63}, {2'd1, 6'd10, 13'd20},
    {2'd0, 6'd0,  13'd3},  {2'd2, 6'd7,  13'd9}
  };

  function automatic int ratio_of(int p, int a, int b);
    int pm = 8;
    for (int i = 0; i < p; i++) pm = pm * 2;
    return pm * b + a;
  endfunction

  function automatic string tag_of(int a, int b);
    if (a == 0)      return "R1 R2 R3";
    else if (a == b) return "R1 R2 R4";
    else if (b == 3) return "R1 R2 R8";
    else             return "R1 R2";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int cnt);
    cnt = 0;
    do begin
      @(posedge clk_in);
      @(negedge clk_in);
      cnt++;
    end while (!div_out && cnt < 70000);
  endtask

  task automatic tick();
    @(posedge clk_in);
    @(negedge clk_in);
  endtask

  task automatic do_reset();
    @(negedge clk_in);
    rst = 1'b1;
    @(negedge clk_in);
    chk(div_out == 1'b0, "R7 div_out in reset", int'(div_out), 0);
    chk(cfg_err == 1'b0, "R7 cfg_err in reset", int'(cfg_err), 0);
    rst = 1'b0;
  endtask

  task automatic apply(input int p, input int a, input int b);
    psel = 2'(p); a_cfg = 6'(a); b_cfg = 13'(b);
  endtask

  initial begin
    repeat (190000) @(posedge clk_in);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int got, exp;
    // table walk: each setting from reset, first and second period
    for (int v = 0; v < 8; v++) begin
      int p = int'(VEC[v][20:19]);
      int a = int'(VEC[v][18:13]);
      int b = int'(VEC[v][12:0]);
      apply(p, a, b);
      do_reset();
      exp = ratio_of(p, a, b);
      measure(got);
      chk(got == exp, {tag_of(a, b), " first period"}, got, exp);
      measure(got);
      chk(got == exp, {tag_of(a, b), " steady period"}, got, exp);
    end

    // R5: invalid settings flagged, old ratio kept
    apply(0, 5, 10);
    do_reset();
    measure(got);
    chk(got == 85, "R1 base period", got, 85);
    apply(0, 12, 10);              // A > B
    tick();
    chk(cfg_err == 1'b1, "R5 err on A>B", int'(cfg_err), 1);
    measure(got);
    chk(got == 84, "R5 rest of cycle", got, 84);
    measure(got);
    chk(got == 85, "R5 ratio held across boundary", got, 85);
    apply(0, 0, 2);                // B below minimum
    tick();
    chk(cfg_err == 1'b1, "R5 err on B<3", int'(cfg_err), 1);
    measure(got);
    chk(got == 84, "R5 ratio held with B<3", got, 84);

    // R6: new valid setting at the boundary, then mid-cycle
    apply(1, 3, 4);
    tick();
    chk(cfg_err == 1'b0, "R5 err cleared", int'(cfg_err), 0);
    measure(got);
    chk(got == 84, "R6 current cycle keeps old length", got, 84);
    measure(got);
    chk(got == 67, "R6 next cycle uses new setting", got, 67);
    repeat (10) tick();
    apply(0, 5, 10);
    measure(got);
    chk(got == 57, "R6 mid-cycle change ignored", got, 57);
    measure(got);
    chk(got == 85, "R6 change applied after boundary", got, 85);

    // R7: reset in mid-cycle restarts counting
    repeat (30) tick();
    apply(2, 7, 9);
    do_reset();
    measure(got);
    chk(got == 295, "R7 restart after mid-cycle reset", got, 295);

    // R8: largest B and largest A
    apply(0, 63, 8191);
    do_reset();
    measure(got);
    chk(got == 65591, "R8 B=8191 A=63", got, 65591);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule